// File: doc/BRIEF.md
# Narrow Pulse Capture Synchronizer

This block carries a single-bit event from an unrelated timing source into a destination clock domain. The source pulse may be far narrower than one destination clock period, so it cannot simply be sampled by a clocked register. Instead, the rising edge of the event clocks a capture register whose data input is tied high. That register's level then passes through a chain of destination-clock registers. The last register of the chain drives the block's output.

The output asynchronously clears the capture register, which rearms the block once the event has crossed. The event has no payload, so there is no valid/ready stream here: both the input and the output are plain control pins. A user places one instance per event line and treats each rising edge of the output as one delivered event. Events that arrive closer together than the rearm time are merged.

Top module: `pulse_catch_sync`

## Requirements
- R1: While `rst_i` is high, `evt_sync_o` is low. After `rst_i` falls with no event applied, `evt_sync_o` stays low for at least two destination clocks.
- R2: A rising edge on `evt_i` between destination edges k and k+1 makes `evt_sync_o` rise at edge k+SYNC_STAGES, which is k+2 with the default. The output is still low after edge k+SYNC_STAGES-1.
- R3: For an isolated event, `evt_sync_o` stays high for exactly SYNC_STAGES destination cycles and then returns low.
- R4: A pulse of 1 ns or less, which is much narrower than the 8 ns clock, is never lost.
- R5: A second rising edge on `evt_i` that arrives before `evt_sync_o` has risen merges with the first event. Together they give one output assertion of the normal width.
- R6: While `evt_sync_o` is high, the capture register is held clear. An input edge in that window is ignored and gives no second output assertion.
- R7: The block rearms when `evt_sync_o` falls. An input edge after that point gives a new, complete output assertion with the R2 latency.
- R8: Raising `rst_i` after an event has been captured but before it reaches the output discards the event: no output assertion follows the release of reset.
- R9: A sequence of well-separated events at random phases gives exactly one output assertion per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Destination-domain clock |
| rst_i | input | 1 | Active-high asynchronous reset of every register |
| evt_i | input | 1 | Asynchronous event; its rising edge is the event |
| evt_sync_o | output | 1 | Event level in the destination domain, high SYNC_STAGES cycles per event |

## Verification
The bench places pulses as narrow as 0.2 ns at random offsets inside a clock period. A design that sampled the input with the clock would miss most of them. It aims a second pulse before the output rises, and again while the output is high. A design whose clear was edge-based, or was released too early, would report two events in either case. It also checks the first edge after the output falls, where a rearm that is one cycle late would drop a legal event. Finally, it applies reset after an event has been captured but before it crosses. A design that left the capture register out of reset would then report an event after reset.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned PCS_MIN_STAGES = 2;

  function automatic int unsigned pcs_clamp_stages(input int unsigned req);
    return (req < PCS_MIN_STAGES) ? PCS_MIN_STAGES : req;
  endfunction
endpackage

// File: rtl/pcs_capture_cell.sv
module pcs_capture_cell (
  input  logic trig_i,
  input  logic clr_i,
  output logic held_o
);
  // Clocked by the event itself; D is a constant one.
  always_ff @(posedge trig_i or posedge clr_i) begin
    if (clr_i) held_o <= 1'b0;
    else       held_o <= 1'b1;
  end
endmodule

// File: rtl/pcs_sync_chain.sv
module pcs_sync_chain #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic first_o,
  output logic q_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] flop_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) flop_q[0] <= 1'b0;
    else       flop_q[0] <= d_i;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) flop_q[g] <= 1'b0;
      else       flop_q[g] <= flop_q[g-1];
    end
  end

  assign first_o = flop_q[0];
  assign q_o     = flop_q[LAST];
endmodule

// File: rtl/pulse_catch_sync.sv
module pulse_catch_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic evt_i,
  output logic evt_sync_o
);
  import pcs_pkg::*;

  localparam int unsigned STAGES = pcs_clamp_stages(SYNC_STAGES);
  localparam int unsigned CNT_W  = $clog2(STAGES + 2);

  logic cap_q;
  logic cap_clr;
  logic first_q;
  logic sync_q;

  // Clear on reset, or once the event has reached the destination domain.
  assign cap_clr = rst_i | sync_q;

  pcs_capture_cell u_cap (
    .trig_i (evt_i),
    .clr_i  (cap_clr),
    .held_o (cap_q)
  );

  pcs_sync_chain #(.DEPTH(STAGES)) u_chain (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .d_i     (cap_q),
    .first_o (first_q),
    .q_o     (sync_q)
  );

  assign evt_sync_o = sync_q;

  // Length of the current high run of the output, for the width check.
  logic [CNT_W-1:0] hi_run;
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)                        hi_run <= '0;
    else if (!sync_q)                 hi_run <= '0;
    else if (hi_run != {CNT_W{1'b1}}) hi_run <= hi_run + 1'b1;
  end

  // R1: the output is low on any edge that follows a cycle in reset.
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    $past(rst_i) |-> !evt_sync_o);

  // R2: the chain only starts when a captured event was present.
  a_r2_chain_needs_capture: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(first_q) |-> $past(cap_q));

  // R3: the output is never high longer than STAGES cycles.
  a_r3_bounded_width: assert property (@(posedge clk_i) disable iff (rst_i)
    hi_run <= CNT_W'(STAGES));

  // R6: the capture register is held clear while the output is high.
  a_r6_capture_held_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_sync_o |-> !cap_q);
endmodule

// File: tb/pulse_catch_sync_test.sv
`timescale 1ns/1ps
module pulse_catch_sync_test;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt = 1'b0;
  logic out;

  int n_tests = 0;
  int n_fail  = 0;
  int rises   = 0;
  int events  = 0;
  logic prev_out = 1'b0;

  pulse_catch_sync #(.SYNC_STAGES(STAGES)) uut (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .evt_sync_o(out)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (out && !prev_out) rises++;
    prev_out <= out;
  end

  // Expected output n edges after the edge that precedes the capture.
  function automatic logic exp_out(input int n);
    return (n >= STAGES) && (n < 2 * STAGES);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Pulse placed off_ps after the current posedge, width w_ps.
  task automatic pulse(input int off_ps, input int w_ps);
    #(real'(off_ps) / 1000.0);
    evt = 1'b1;
    #(real'(w_ps) / 1000.0);
    evt = 1'b0;
  endtask

  task automatic sample_edge;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Checks an isolated event window of 2*STAGES edges after edge k.
  task automatic check_window(input string req);
    for (int n = 1; n <= 2 * STAGES; n++) begin
      sample_edge();
      check(req, out, exp_out(n));
    end
  endtask

  initial begin
    repeat (3) sample_edge();
    check("R1", out, 1'b0);
    #1 rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      sample_edge();
      check("R1", out, 1'b0);
    end

    // R2/R3/R4: single narrow pulse, latency and width.
    @(posedge clk);
    pulse(2000, 1000);
    events++;
    check_window("R2_R3");

    // R4: very narrow pulse, 0.2 ns.
    @(posedge clk);
    pulse(5500, 200);
    events++;
    check_window("R4");

    // R5: two pulses before the output rises merge into one.
    repeat (2) sample_edge();
    @(posedge clk);
    pulse(1000, 500);
    events++;
    @(posedge clk);
    pulse(3000, 500);
    check("R5", out, 1'b0);
    sample_edge();
    check("R5", out, 1'b1);
    sample_edge();
    check("R5", out, 1'b1);
    sample_edge();
    check("R5", out, 1'b0);
    repeat (2) sample_edge();
    check("R5", out, 1'b0);

    // R6/R7: pulse while output is high is ignored; pulse right after fall rearms.
    @(posedge clk);
    pulse(2000, 500);
    events++;
    @(posedge clk);
    @(posedge clk);               // edge k+2: output now high
    pulse(2000, 500);             // ignored
    @(posedge clk);               // edge k+3: output still high
    pulse(3000, 500);             // ignored
    @(posedge clk);               // edge k+4: output falls, rearmed
    #1;
    check("R6", out, 1'b0);
    pulse(2000, 500);             // between k+4 and k+5: accepted
    events++;
    @(negedge clk);
    check_window("R7");
    repeat (4) sample_edge();
    check("R6", out, 1'b0);

    // R8: reset after capture discards the event.
    @(posedge clk);
    pulse(1000, 500);
    #0.5 rst = 1'b1;
    repeat (3) sample_edge();
    check("R8", out, 1'b0);
    #1 rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      sample_edge();
      check("R8", out, 1'b0);
    end
    n_tests++;
    if (rises != events) begin
      n_fail++;
      $display("FAIL R8: rises %0d expected %0d", rises, events);
    end

    // R9: random well-separated events at random phases.
    begin
      int seed_val;
      seed_val = $urandom(32'h5eed);
      for (int e = 0; e < 40; e++) begin
        @(posedge clk);
        pulse($urandom_range(300, 5500), $urandom_range(150, 1500));
        events++;
        check_window("R9");
        repeat ($urandom_range(0, 4)) sample_edge();
      end
    end
    repeat (2) sample_edge();
    n_tests++;
    if (rises != events) begin
      n_fail++;
      $display("FAIL R9: rises %0d expected %0d", rises, events);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule